// File: doc/BRIEF.md
# Sampling Converter Host Interface Controller

This block is the digital front of an eight-input multiplexed sampling converter. It holds the channel select, works out from the chip-select, write, read and slow-mode pins which of three host modes is in force, and starts conversions in the converter datapath. Every conversion is marked by a one-clock active-low sample strobe. In slow mode a one-clock end-of-conversion pulse follows once the result has been captured. The captured result is 10 code bits plus an out-of-range flag. It goes to the host bus either as one 11-bit word or as two byte halves, with the flag placed in the high half.

There are three modes. Slow mode starts one conversion for each falling edge of write. Fast mode converts back to back for as long as write is held low, and chip select plays no part in starting. The hardwired continuous mode runs when slow mode is selected and chip select, read and write are all held low. The datapath hands each result over through a valid/ready pair. In fast mode `res_ready` stays low while a read is in progress, and the datapath must hold `res_valid`, `res_data` and `res_ovr` steady until the cycle in which `res_ready` is high. Instead of true tri-state, the output bus has a separate enable for each bit. All timing is counted in clock cycles.

Top module: `adc_host_ctrl`

## Requirements
- R1: `ch_sel` follows `addr` combinationally while `addr_le` is high and `cs_n` is low. Otherwise it keeps the last address seen while open. It is 0 after reset.
- R2: In slow mode (`slow_sel`=1, and not all of `cs_n`, `rd_n`, `wr_n` low), a falling edge of `wr_n` sampled with `cs_n` low starts a conversion. `conv_start` is high and `sample_n` is low for exactly the one cycle after that edge. With `cs_n` high, a `wr_n` edge starts nothing.
- R3: `eoc` is high for one cycle, right after the clock edge that takes a result in, but only when that result belongs to a slow-mode conversion. In fast and continuous modes `eoc` stays low.
- R4: In fast mode (`slow_sel`=0), a low level on `wr_n` starts conversions whatever `cs_n` is. Held low, it gives a new `sample_n` low cycle every CONV_CYC (default 3) clocks.
- R5: With `slow_sel` high and `cs_n`, `rd_n` and `wr_n` all low, conversions run every CONV_CYC clocks, and each result is taken in while the read is active.
- R6: A slow-mode start request that arrives while a conversion is still running is dropped.
- R7: In fast mode, `res_ready` is low while `cs_n` and `rd_n` are both low, and the output latch keeps its value.
- R8: With `cs_n` low, `rd_n` low and `bus_wide` high, all 11 enables are set, and `dq` = {ovr, code[9:0]}.
- R9: With `bus_wide` low, `hi_sel`=0 enables bits 7..0 only, and `hi_sel`=1 enables bits 10..8 only (code bits 9 and 8 plus ovr).
- R10: When `rd_n` or `cs_n` is high, every bit of `dq_oe` and of `dq` is 0.
- R11: In slow mode, if a read is active within WIN_CYC (default 1) clocks after the start edge, that conversion falls back to continuous-mode behaviour and raises no `eoc`. A read that comes later leaves `eoc` in place.
- R12: After reset, `sample_n`=1, `eoc`=0, `conv_start`=0, `dq_oe`=0 and the result latch holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_le | input | 1 | Address latch enable, transparent while high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write / conversion request, active low |
| rd_n | input | 1 | Read, active low |
| slow_sel | input | 1 | 1 = slow or continuous mode, 0 = fast mode |
| bus_wide | input | 1 | 1 = drive the whole word, 0 = byte halves |
| hi_sel | input | 1 | Byte half select when `bus_wide` is 0 |
| addr | input | 3 | Channel address |
| ch_sel | output | 3 | Selected channel |
| conv_start | output | 1 | One-cycle start pulse to the datapath |
| sample_n | output | 1 | Active-low sample strobe |
| eoc | output | 1 | End-of-conversion pulse |
| res_valid | input | 1 | Datapath result valid |
| res_ready | output | 1 | Result latch can accept |
| res_data | input | 10 | Result code, two's complement |
| res_ovr | input | 1 | Out-of-range flag |
| dq | output | 11 | Output bus value {ovr, code} |
| dq_oe | output | 11 | Per-bit output enable |

## Verification
The hardest case to reach is the read that comes just after a slow-mode start, because it must land inside a window only WIN_CYC clocks wide. The bench pulses write, then at the very next falling clock edge raises write and lowers read together. It then repeats the sequence with the read one cycle later and expects `eoc` to come back. The fast-mode freeze needs a result that is offered while a read is held. That result must stay pending over several cycles and only be taken in the edge after read is released.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic [1:0] {
    MODE_SLOW = 2'd0,
    MODE_FAST = 2'd1,
    MODE_DMA  = 2'd2
  } if_mode_e;
endpackage

// File: rtl/adc_chan_latch.sv
module adc_chan_latch #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_le,
  input  logic            cs_n,
  input  logic [CH_W-1:0] addr,
  output logic [CH_W-1:0] ch_sel
);
  logic [CH_W-1:0] ch_q;
  logic            open_w;

  assign open_w = addr_le && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ch_q <= '0;
    else if (open_w) ch_q <= addr;
  end

  // transparent path while open, held value otherwise
  assign ch_sel = open_w ? addr : ch_q;

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_le || cs_n) |=> $stable(ch_q));
endmodule

// File: rtl/adc_mode_decode.sv
module adc_mode_decode
  import adc_if_pkg::*;
(
  input  logic     slow_sel,
  input  logic     cs_n,
  input  logic     wr_n,
  input  logic     rd_n,
  output if_mode_e mode,
  output logic     rd_act
);
  assign rd_act = !cs_n && !rd_n;

  always_comb begin
    if (!slow_sel)                 mode = MODE_FAST;
    else if (rd_act && !wr_n)      mode = MODE_DMA;
    else                           mode = MODE_SLOW;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_if_pkg::*;
#(
  parameter int CONV_CYC = 3,
  parameter int WIN_CYC  = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  if_mode_e mode,
  input  logic     cs_n,
  input  logic     wr_n,
  input  logic     rd_act,
  input  logic     accept,
  output logic     conv_start,
  output logic     sample_n,
  output logic     eoc
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int AW = $clog2(WIN_CYC + 2);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYC - 1);
  localparam logic [AW-1:0] AGE_SAT  = AW'(WIN_CYC);

  logic          active;
  logic [CW-1:0] cnt;
  logic          wr_prev;
  logic [AW-1:0] age;
  logic          eoc_en;
  logic          req;
  logic          start_ok;
  logic          start;

  // a running conversion may be followed at its last cycle (continuous rate)
  assign start_ok = !active || (cnt == '0);

  always_comb begin
    case (mode)
      MODE_SLOW: req = !cs_n && wr_prev && !wr_n;
      MODE_FAST: req = !wr_n;
      MODE_DMA:  req = 1'b1;
      default:   req = 1'b0;
    endcase
  end

  assign start = req && start_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      wr_prev    <= 1'b1;
      age        <= AGE_SAT;
      eoc_en     <= 1'b0;
      conv_start <= 1'b0;
      sample_n   <= 1'b1;
      eoc        <= 1'b0;
    end else begin
      wr_prev    <= wr_n;
      conv_start <= start;
      sample_n   <= !start;
      eoc        <= accept && eoc_en;
      if (start) begin
        active <= 1'b1;
        cnt    <= CNT_LOAD;
      end else if (active) begin
        if (cnt == '0) active <= 1'b0;
        else           cnt    <= cnt - 1'b1;
      end
      if (start)              age <= '0;
      else if (age < AGE_SAT) age <= age + 1'b1;
      if (start)
        eoc_en <= (mode == MODE_SLOW) && !rd_act;
      else if (accept || (rd_act && (age < AGE_SAT)))
        eoc_en <= 1'b0;
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_n |=> sample_n);
  p_cs_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLOW && cs_n) |=> !conv_start);
  p_start_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_eoc_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
  import adc_if_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  if_mode_e          mode,
  input  logic              rd_act,
  input  logic              bus_wide,
  input  logic              hi_sel,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_ovr,
  output logic              res_ready,
  output logic              accept,
  output logic [DATA_W:0]   dq,
  output logic [DATA_W:0]   dq_oe
);
  localparam int W    = DATA_W + 1;
  localparam int HI_W = W - BYTE_W;

  logic [W-1:0] word_q;

  // fast mode freezes the latch while the host reads it
  assign res_ready = !((mode == MODE_FAST) && rd_act);
  assign accept    = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= {res_ovr, res_data};
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam bit IN_HI = (i >= BYTE_W);
    assign dq_oe[i] = rd_act && (bus_wide || (hi_sel == IN_HI));
    assign dq[i]    = dq_oe[i] && word_q[i];
  end

  p_fast_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && rd_act) |=> $stable(word_q));
  p_byte_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dq_oe) == 0) || ($countones(dq_oe) == BYTE_W) ||
    ($countones(dq_oe) == HI_W) || ($countones(dq_oe) == W));
  p_idle_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> (dq_oe == '0 && dq == '0));
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_if_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int DATA_W   = 10,
  parameter int BYTE_W   = 8,
  parameter int CONV_CYC = 3,
  parameter int WIN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_le,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              slow_sel,
  input  logic              bus_wide,
  input  logic              hi_sel,
  input  logic [CH_W-1:0]   addr,
  output logic [CH_W-1:0]   ch_sel,
  output logic              conv_start,
  output logic              sample_n,
  output logic              eoc,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_ovr,
  output logic [DATA_W:0]   dq,
  output logic [DATA_W:0]   dq_oe
);
  if_mode_e mode;
  logic     rd_act;
  logic     accept;

  adc_chan_latch #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .addr_le(addr_le), .cs_n(cs_n),
    .addr(addr), .ch_sel(ch_sel)
  );

  adc_mode_decode u_mode (
    .slow_sel(slow_sel), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .mode(mode), .rd_act(rd_act)
  );

  adc_conv_seq #(.CONV_CYC(CONV_CYC), .WIN_CYC(WIN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .wr_n(wr_n),
    .rd_act(rd_act), .accept(accept), .conv_start(conv_start),
    .sample_n(sample_n), .eoc(eoc)
  );

  adc_out_stage #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_act(rd_act),
    .bus_wide(bus_wide), .hi_sel(hi_sel), .res_valid(res_valid),
    .res_data(res_data), .res_ovr(res_ovr), .res_ready(res_ready),
    .accept(accept), .dq(dq), .dq_oe(dq_oe)
  );

  p_dma_no_eoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DMA && $past(mode) == MODE_DMA && $past(mode, 2) == MODE_DMA) |-> !eoc);
endmodule

// File: tb/adc_host_ctrl_bench.sv
`timescale 1ns/100ps
module adc_host_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_le = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic slow_sel = 1'b1, bus_wide = 1'b1, hi_sel = 1'b0;
  logic [2:0] addr = '0;
  logic [2:0] ch_sel;
  logic conv_start, sample_n, eoc, res_ready;
  logic res_valid = 1'b0, res_ovr = 1'b0;
  logic [9:0] res_data = '0;
  logic [10:0] dq, dq_oe;

  int total = 0, bad = 0;
  bit done = 0;
  bit acc_seen = 0;
  bit exp_q[$];
  logic [10:0] last_word = '0;

  always #2.5 clk = ~clk;

  adc_host_ctrl u_adc_host_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_le(addr_le), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .slow_sel(slow_sel), .bus_wide(bus_wide), .hi_sel(hi_sel),
    .addr(addr), .ch_sel(ch_sel), .conv_start(conv_start), .sample_n(sample_n),
    .eoc(eoc), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ovr(res_ovr), .dq(dq), .dq_oe(dq_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one expected eoc value per accepted result
  always @(posedge clk) acc_seen <= res_valid && res_ready;
  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_seen) begin
        if (exp_q.size() == 0) chk("R3 unexpected accept", 1, 0);
        else chk("R3 eoc after accept", {31'd0, eoc}, {31'd0, exp_q.pop_front()});
      end else if (eoc) chk("R3 eoc without accept", {31'd0, eoc}, 0);
    end
  end

  // driver: offer a result, wait for acceptance, queue the expected eoc
  task automatic send(logic ovr, logic [9:0] d, bit exp_eoc);
    exp_q.push_back(exp_eoc);
    res_ovr = ovr; res_data = d; res_valid = 1'b1;
    forever begin
      @(posedge clk);
      if (res_ready) break;
    end
    @(negedge clk);
    res_valid = 1'b0;
    last_word = {ovr, d};
  endtask

  task automatic read_check(string req, bit wide, bit hi);
    cs_n = 1'b0; rd_n = 1'b0; bus_wide = wide; hi_sel = hi;
    #1;
    if (wide) begin
      chk(req, dq_oe, 11'h7FF); chk(req, dq, last_word);
    end else if (hi) begin
      chk(req, dq_oe, 11'h700); chk(req, dq, last_word & 11'h700);
    end else begin
      chk(req, dq_oe, 11'h0FF); chk(req, dq, last_word & 11'h0FF);
    end
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R12 reset state
    chk("R12 sample_n", sample_n, 1); chk("R12 eoc", eoc, 0);
    chk("R12 conv_start", conv_start, 0); chk("R12 oe", dq_oe, 0);
    chk("R1 reset channel", ch_sel, 0);
    rst_n = 1'b1;
    idle(1);
    read_check("R12 latch zero", 1, 0);
    cs_n = 1'b1;

    // R1 address latch
    cs_n = 1'b0; addr_le = 1'b1; addr = 3'd5; #1;
    chk("R1 transparent", ch_sel, 5);
    @(negedge clk); addr_le = 1'b0; addr = 3'd2;
    @(negedge clk); chk("R1 held", ch_sel, 5);
    cs_n = 1'b1; addr_le = 1'b1; addr = 3'd7;
    @(negedge clk); chk("R1 cs blocks", ch_sel, 5);
    addr_le = 1'b0;

    // R2 cs high blocks a slow start
    slow_sel = 1'b1; wr_n = 1'b0;
    @(negedge clk); chk("R2 cs blocks start", sample_n, 1);
    wr_n = 1'b1; idle(1);

    // R2 slow start, R6 dropped request
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); chk("R2 strobe low", sample_n, 0); chk("R2 start", conv_start, 1);
    wr_n = 1'b1;
    @(negedge clk); chk("R2 strobe one cycle", sample_n, 1);
    wr_n = 1'b0;
    @(negedge clk); chk("R6 busy drop", sample_n, 1);
    wr_n = 1'b1;
    @(negedge clk); chk("R6 busy drop late", sample_n, 1);
    send(1'b0, 10'h155, 1);            // R3 eoc expected
    idle(1);
    read_check("R8 wide", 1, 0);
    read_check("R9 high half", 0, 1);
    read_check("R9 low half", 0, 0);
    send(1'b1, 10'h2AA, 0);            // no new start: no eoc
    read_check("R9 high half ovr", 0, 1);
    rd_n = 1'b1; #1; chk("R10 rd high", dq_oe, 0); chk("R10 rd high dq", dq, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1; chk("R10 cs high", dq_oe, 0);
    rd_n = 1'b1; cs_n = 1'b0;
    idle(4);

    // R11 read inside the window: no eoc
    wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    idle(3);
    send(1'b0, 10'h0F0, 0);
    idle(2);
    // R11 read after the window: eoc remains
    wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    idle(2);
    send(1'b0, 10'h00F, 1);
    idle(3);

    // R4 fast mode, continuous with cs high
    slow_sel = 1'b0; cs_n = 1'b1; wr_n = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      chk("R4 strobe period", sample_n, (i % 3 == 1) ? 0 : 1);
      chk("R4 no eoc", eoc, 0);
    end
    wr_n = 1'b1;
    send(1'b0, 10'h123, 0);            // R3 no eoc in fast mode
    idle(3);

    // R7 fast read freezes latch
    cs_n = 1'b0; rd_n = 1'b0; bus_wide = 1'b1;
    exp_q.push_back(0);
    res_ovr = 1'b1; res_data = 10'h3C3; res_valid = 1'b1;
    #1; chk("R7 ready low", res_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 latch frozen", dq, last_word);
    end
    rd_n = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; last_word = {1'b1, 10'h3C3}; rd_n = 1'b0; #1;
    chk("R7 update after read", dq, last_word);
    @(negedge clk); rd_n = 1'b1;
    idle(2);

    // R5 hardwired continuous mode
    slow_sel = 1'b1; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; bus_wide = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R5 strobe period", sample_n, (i % 3 == 1) ? 0 : 1);
    end
    send(1'b0, 10'h2D4, 0);
    chk("R5 latch updates under read", dq, {1'b0, 10'h2D4});
    chk("R5 no eoc", eoc, 0);
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    idle(4);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule